// File: doc/BRIEF.md
# Vector Fail-on-First Length Truncator

This block sequences the elements of one vector instruction and decides, element by element, whether the vector may keep running. A start pulse loads the vector length and the configuration. After that, each incoming element's 4-bit condition field is tested on one selected bit. The element stream uses a valid signal, and at most one element is accepted per cycle. The block drives the result-write and condition-write enables for each accepted element, together with the element index.

The test is deterministic. An element fails when its selected condition bit equals the invert flag. When an element fails, the loop ends and the length is cut back to the failing index. If the inclusive flag is in effect, the length is cut back to the failing index plus one instead. The inclusive flag is in effect only when the Rc flag is clear. A condition-only mode suppresses every result write and keeps the condition writes. When no element fails, the length is unchanged.

The controller has three states. IDLE waits for start. RUN accepts elements. FIN raises done for one cycle. The transitions are:
- IDLE→FIN on a start with length 0.
- IDLE→RUN on a start with any other length.
- RUN→FIN on a failing element, or on the last element of the vector.
- FIN→IDLE always.

Top module: `ffirst_seq`

## Requirements
- R1: Elements are accepted only in RUN and only while `el_valid` is high, at most one per cycle. `el_idx` starts at 0 after start and rises by one per accepted element. A cycle with `el_valid` low writes nothing and does not advance the index.
- R2: The condition field is encoded as bit0=lt, bit1=gt, bit2=eq, bit3=so. `cfg_sel` selects one of these bits (0=lt, 1=gt, 2=eq, 3=so). An element fails when that bit equals `cfg_inv`.
- R3: A failing element ends the loop. `done` is high for exactly one cycle, in the cycle after the element is accepted. Elements presented after that are not written.
- R4: After a failure, `vlen_out` equals the failing index when the inclusive flag is not in effect. It equals the failing index plus one when the flag is in effect.
- R5: When `cfg_rc` is 1, `cfg_incl` is ignored and treated as clear.
- R6: When `cfg_cronly` is 1, `res_we` is never asserted. `cond_we` still follows R8.
- R7: When no element fails, `vlen_out` equals `vlen_in`. `done` pulses in the cycle after the last element is accepted.
- R8: Every accepted element has `cond_we`=1. `res_we` is 1 for a passing element, and for the failing element only when the inclusive flag is in effect. In both cases `res_we` is 0 whenever condition-only mode is on.
- R9: A start with `vlen_in`=0 gives `done` on the next cycle with `vlen_out`=0 and no writes.
- R10: Length and configuration are sampled on the start pulse. A start while the block is not in IDLE is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new vector instruction |
| vlen_in | input | VL_W | Vector length for this instruction |
| cfg_sel | input | 2 | Condition bit to test |
| cfg_inv | input | 1 | Value of the selected bit that counts as a failure |
| cfg_incl | input | 1 | Keep the failing element in the length |
| cfg_rc | input | 1 | Rc flag; when set, the inclusive flag is disabled |
| cfg_cronly | input | 1 | Write condition fields only |
| el_valid | input | 1 | Element condition field present |
| el_cond | input | 4 | Element condition field {so,eq,gt,lt} |
| res_we | output | 1 | Write result of current element |
| cond_we | output | 1 | Write condition field of current element |
| el_idx | output | VL_W | Index of current element |
| vlen_out | output | VL_W | Truncated vector length, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The index register and the state register are the sensitive internals. A wrong index shows at once on `el_idx`, in the same cycle as the element's write enables. One cycle later it shows on `vlen_out`, because the truncated length is computed from the index. A state that leaves RUN early or late shows as `done` one cycle off, or as writes to elements beyond the failing one. A latched configuration bit that is wrong shows at the failing element, as a flipped `res_we` or a length one off. Each scenario therefore checks the enables on every element, as well as the length and the single-cycle `done`.

// File: rtl/ffirst_pkg.sv
package ffirst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } ffst_t;

    typedef enum logic [1:0] {
        SEL_LT = 2'd0,
        SEL_GT = 2'd1,
        SEL_EQ = 2'd2,
        SEL_SO = 2'd3
    } csel_t;

    typedef struct packed {
        logic [1:0] sel;
        logic       inv;
        logic       incl_eff;
        logic       cro;
    } ffcfg_t;
endpackage

// File: rtl/ffirst_bittest.sv
module ffirst_bittest #(
    parameter int CW = 4,
    localparam int SW = $clog2(CW)
) (
    input  logic [CW-1:0] cond,
    input  logic [SW-1:0] sel,
    input  logic          inv,
    output logic          fail
);
    always_comb begin
        fail = (cond[sel] == inv);
    end
endmodule

// File: rtl/ffirst_lencalc.sv
module ffirst_lencalc #(
    parameter int VL_W = 7
) (
    input  logic [VL_W-1:0] idx,
    input  logic [VL_W-1:0] vl,
    input  logic            fail,
    input  logic            incl,
    output logic [VL_W-1:0] len
);
    always_comb begin
        if (fail)
            len = idx + VL_W'(incl);
        else
            len = vl;
    end
endmodule

// File: rtl/ffirst_seq.sv
module ffirst_seq
    import ffirst_pkg::*;
#(
    parameter int VL_W = 7,
    parameter int CW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VL_W-1:0] vlen_in,
    input  logic [1:0]      cfg_sel,
    input  logic            cfg_inv,
    input  logic            cfg_incl,
    input  logic            cfg_rc,
    input  logic            cfg_cronly,
    input  logic            el_valid,
    input  logic [CW-1:0]   el_cond,
    output logic            res_we,
    output logic            cond_we,
    output logic [VL_W-1:0] el_idx,
    output logic [VL_W-1:0] vlen_out,
    output logic            done
);
    ffst_t           st, st_nx;
    ffcfg_t          cfg_q;
    logic [VL_W-1:0] vl_q;
    logic [VL_W-1:0] idx_q;
    logic [VL_W-1:0] len_nx;
    logic            el_fail;
    logic            take;
    logic            last_el;
    logic            idle_st;
    logic            run_st;
    logic            cro_q;

    ffirst_bittest #(.CW(CW)) u_test (
        .cond (el_cond),
        .sel  (cfg_q.sel),
        .inv  (cfg_q.inv),
        .fail (el_fail)
    );

    ffirst_lencalc #(.VL_W(VL_W)) u_len (
        .idx  (idx_q),
        .vl   (vl_q),
        .fail (el_fail),
        .incl (cfg_q.incl_eff),
        .len  (len_nx)
    );

    assign idle_st = (st == ST_IDLE);
    assign run_st  = (st == ST_RUN);
    assign cro_q   = cfg_q.cro;
    assign take    = run_st && el_valid;
    assign last_el = (idx_q == vl_q - VL_W'(1));

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) st_nx = (vlen_in == '0) ? ST_FIN : ST_RUN;
            ST_RUN:  if (take && (el_fail || last_el)) st_nx = ST_FIN;
            ST_FIN:  st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cfg_q    <= '0;
            vl_q     <= '0;
            idx_q    <= '0;
            vlen_out <= '0;
        end else begin
            st <= st_nx;
            if (idle_st && start) begin
                cfg_q.sel      <= cfg_sel;
                cfg_q.inv      <= cfg_inv;
                cfg_q.incl_eff <= cfg_incl & ~cfg_rc;
                cfg_q.cro      <= cfg_cronly;
                vl_q           <= vlen_in;
                idx_q          <= '0;
                vlen_out       <= '0;
            end else if (take) begin
                if (el_fail || last_el)
                    vlen_out <= len_nx;
                else
                    idx_q <= idx_q + VL_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        cond_we = 1'b0;
        res_we  = 1'b0;
        done    = 1'b0;
        el_idx  = idx_q;
        unique case (st)
            ST_IDLE: ;
            ST_RUN: begin
                cond_we = take;
                res_we  = take && !cfg_q.cro && (!el_fail || cfg_q.incl_eff);
            end
            ST_FIN:  done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ffirst_seq_chk.sv
module ffirst_seq_chk #(
    parameter int VL_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [VL_W-1:0] vlen_in,
    input logic            res_we,
    input logic            cond_we,
    input logic [VL_W-1:0] el_idx,
    input logic [VL_W-1:0] vlen_out,
    input logic            done,
    input logic            idle_st,
    input logic            run_st,
    input logic            cro_q,
    input logic [VL_W-1:0] vl_q
);
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_st && $past(run_st) && $past(cond_we) && cond_we) |-> (el_idx == $past(el_idx) + VL_W'(1)));

    p_first_idx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_st && start && vlen_in != '0) |=> (el_idx == '0));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_quiet_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cond_we && !res_we));

    p_res_needs_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> cond_we);

    p_cronly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_st && cro_q) |-> !res_we);

    p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vlen_out <= vl_q));

    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_st && start && vlen_in == '0) |=> (done && vlen_out == '0));
endmodule

bind ffirst_seq ffirst_seq_chk #(.VL_W(VL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vlen_in  (vlen_in),
    .res_we   (res_we),
    .cond_we  (cond_we),
    .el_idx   (el_idx),
    .vlen_out (vlen_out),
    .done     (done),
    .idle_st  (idle_st),
    .run_st   (run_st),
    .cro_q    (cro_q),
    .vl_q     (vl_q)
);

// File: tb/ffirst_seq_test.sv
module ffirst_seq_test;
    localparam int VL_W = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [VL_W-1:0] vlen_in = '0;
    logic [1:0]      cfg_sel = '0;
    logic            cfg_inv = 1'b0;
    logic            cfg_incl = 1'b0;
    logic            cfg_rc = 1'b0;
    logic            cfg_cronly = 1'b0;
    logic            el_valid = 1'b0;
    logic [3:0]      el_cond = '0;
    logic            res_we, cond_we, done;
    logic [VL_W-1:0] el_idx, vlen_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [3:0] cv [16];

    always #2.5 clk = ~clk;

    ffirst_seq #(.VL_W(VL_W), .CW(4)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vlen_in(vlen_in),
        .cfg_sel(cfg_sel), .cfg_inv(cfg_inv), .cfg_incl(cfg_incl),
        .cfg_rc(cfg_rc), .cfg_cronly(cfg_cronly), .el_valid(el_valid),
        .el_cond(el_cond), .res_we(res_we), .cond_we(cond_we),
        .el_idx(el_idx), .vlen_out(vlen_out), .done(done)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Runs one instruction; expected values come from the requirements.
    task automatic run_case(string tag, int vl, logic [1:0] sel, logic inv,
                            logic incl, logic rc, logic cro, bit gaps);
        int fi = vl;
        int last;
        int exp_len;
        logic incl_e = incl & ~rc;
        for (int i = 0; i < vl; i++) begin
            if (cv[i][sel] == inv) begin fi = i; break; end
        end
        exp_len = (fi < vl) ? fi + int'(incl_e) : vl;
        last = (fi < vl) ? fi : vl - 1;
        @(negedge clk);
        vlen_in = VL_W'(vl); cfg_sel = sel; cfg_inv = inv; cfg_incl = incl;
        cfg_rc = rc; cfg_cronly = cro; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // scramble config after start: R10 says it was sampled already
        cfg_inv = ~inv; cfg_cronly = ~cro; cfg_incl = ~incl;
        if (vl == 0) begin
            #1;
            chk({tag, " R9 done"}, int'(done), 1);
            chk({tag, " R9 len"}, int'(vlen_out), 0);
            chk({tag, " R9 nowrite"}, int'(cond_we | res_we), 0);
            @(negedge clk);
            chk({tag, " R3 pulse"}, int'(done), 0);
            return;
        end
        for (int i = 0; i <= last; i++) begin
            if (gaps && i == 1) begin
                el_valid = 1'b0; el_cond = cv[i];
                #1;
                chk({tag, " R1 gap nowrite"}, int'(cond_we | res_we), 0);
                @(negedge clk);
                #1;
                chk({tag, " R1 gap idx"}, int'(el_idx), 1);
            end
            el_valid = 1'b1; el_cond = cv[i];
            #1;
            chk({tag, " R1 idx"}, int'(el_idx), i);
            chk({tag, " R8 cond_we"}, int'(cond_we), 1);
            chk({tag, " R6/R8 res_we"}, int'(res_we),
                int'(!cro && (i != fi || incl_e)));
            @(negedge clk);
            el_valid = 1'b0;
            if (i < last) begin
                #1;
                chk({tag, " R3 no early done"}, int'(done), 0);
            end
        end
        // the element after the end is offered: it must not be written
        el_valid = 1'b1; el_cond = cv[last + 1 < 16 ? last + 1 : 15];
        #1;
        chk({tag, " R3/R7 done"}, int'(done), 1);
        chk({tag, " R4/R5/R7 len"}, int'(vlen_out), exp_len);
        chk({tag, " R3 discard"}, int'(cond_we | res_we), 0);
        @(negedge clk);
        #1;
        chk({tag, " R3 pulse"}, int'(done), 0);
        chk({tag, " R3 discard idle"}, int'(cond_we | res_we), 0);
        el_valid = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("reset done", int'(done), 0);
        chk("reset R1 writes", int'(cond_we | res_we), 0);
        chk("reset len", int'(vlen_out), 0);
    endtask

    task automatic t_nofail();
        for (int i = 0; i < 16; i++) cv[i] = 4'b0000;
        run_case("R7 nofail eq", 6, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_fail_excl();
        for (int i = 0; i < 16; i++) cv[i] = 4'b0001;
        cv[3] = 4'b1110;
        run_case("R4 excl lt", 8, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_fail_incl();
        for (int i = 0; i < 16; i++) cv[i] = 4'b0000;
        cv[4] = 4'b0010;
        run_case("R4 incl gt", 9, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_rc_ignores_incl();
        for (int i = 0; i < 16; i++) cv[i] = 4'b0000;
        cv[2] = 4'b1000;
        run_case("R5 rc so", 7, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_cronly();
        for (int i = 0; i < 16; i++) cv[i] = 4'b0100;
        cv[5] = 4'b0000;
        run_case("R6 cronly", 10, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_first_fail();
        for (int i = 0; i < 16; i++) cv[i] = 4'b1111;
        run_case("R2 fail idx0", 5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_zero();
        for (int i = 0; i < 16; i++) cv[i] = 4'b0000;
        run_case("R9 zero", 0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_gaps_last();
        for (int i = 0; i < 16; i++) cv[i] = 4'b0010;
        cv[3] = 4'b0000;
        run_case("R1 gaps last incl", 4, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_restart_busy();
        // R10: a second start in RUN is ignored
        for (int i = 0; i < 16; i++) cv[i] = 4'b0000;
        @(negedge clk);
        vlen_in = 7'd3; cfg_sel = 2'd2; cfg_inv = 1'b1; cfg_incl = 1'b0;
        cfg_rc = 1'b0; cfg_cronly = 1'b0; start = 1'b1;
        @(negedge clk);
        vlen_in = 7'd1; start = 1'b1; el_valid = 1'b1; el_cond = 4'b0000;
        #1;
        chk("R10 idx0", int'(el_idx), 0);
        @(negedge clk);
        start = 1'b0;
        #1;
        chk("R10 restart ignored", int'(el_idx), 1);
        chk("R10 no done", int'(done), 0);
        @(negedge clk);
        el_valid = 1'b0;
        #1;
        chk("R10 idx2", int'(el_idx), 2);
        el_valid = 1'b1;
        @(negedge clk);
        el_valid = 1'b0;
        #1;
        chk("R10 done", int'(done), 1);
        chk("R10 len", int'(vlen_out), 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_nofail();
        t_fail_excl();
        t_fail_incl();
        t_rc_ignores_incl();
        t_cronly();
        t_first_fail();
        t_zero();
        t_gaps_last();
        t_restart_busy();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule